// File: doc/BRIEF.md
# Power-Mode Direct-Transition Controller

This block tracks which running or low-power mode a microcontroller is in and decides what a sleep request does. A plain request halts the processor in a sleep or watch state until a wake interrupt arrives. When direct transitions are enabled and the control bits describe a legal move, the request instead carries the part from one running mode to another. The three running modes are high-speed, medium-speed and subactive. The move passes briefly through sleep or watch and ends with a one-cycle interrupt request, so execution carries on at the new speed.

The move from subactive to high-speed must wait for the fast oscillator to settle. A 3-bit field selects a wait of 2^(field+6) cycles, from 64 to 8192, and the controller spends that time in watch. A global interrupt mask set at the moment of a direct attempt leaves the part in sleep or watch, and no interrupt can release it. Only reset brings it back. The block drives a clock-speed select and a CPU-halt line. The clock generator itself sits outside.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, mode is 0 (high-speed), clk_sel is 2'b00, cpu_halt is 0 and dt_irq is 0.
- R2: In high-speed mode, a sleep request with sby_sel=0, lspd_on=0, mspd_on=1, dt_en=1, dt_irq_en=1 and gmask=0 shows mode 3 (sleep) for exactly one cycle, then mode 1 (medium-speed).
- R3: In medium-speed mode, the same request with mspd_on=0 shows mode 3 for one cycle, then mode 0 (high-speed).
- R4: In high-speed or medium-speed mode, a sleep request with sby_sel=1, lspd_on=1, dt_en=1, tmr_sel=1, dt_irq_en=1 and gmask=0 shows mode 4 (watch) for one cycle, then mode 2 (subactive).
- R5: In subactive mode, a sleep request with sby_sel=1, lspd_on=0, mspd_on=0, dt_en=1, tmr_sel=1, dt_irq_en=1 and gmask=0 shows mode 4 for exactly 2^(settle_sel+6) cycles, then mode 0.
- R6: dt_irq is high for exactly one cycle, in the first cycle that shows the target running mode of a completed direct transition, and at no other time.
- R7: A matching direct request with dt_irq_en=0 enters sleep (sby_sel=0) or watch (sby_sel=1) and stays there with no dt_irq. A later wake_irq with gmask=0 returns it to the prior running mode.
- R8: A matching direct request with gmask=1 enters sleep or watch, and wake_irq never releases it until reset.
- R9: A sleep request with dt_en=0, or with no matching direct path, enters sleep (sby_sel=0) or watch (sby_sel=1). wake_irq returns it to the prior running mode only when gmask=0 in that cycle.
- R10: clk_sel is 2'b00 for high-speed, 2'b01 for medium-speed and 2'b10 for subactive. It follows the running mode and keeps the prior mode's value throughout sleep, watch and any settling wait.
- R11: sleep_req has no effect in sleep or watch. wake_irq has no effect in a running mode or during a direct pass-through.
- R12: mode encodes 0 high-speed, 1 medium-speed, 2 subactive, 3 sleep, 4 watch. cpu_halt is 1 exactly when mode is 3 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | One-cycle sleep request from the CPU |
| sby_sel | input | 1 | Standby select: 0 routes via sleep, 1 via watch |
| lspd_on | input | 1 | Low-speed (subactive) target select |
| mspd_on | input | 1 | Medium-speed select |
| dt_en | input | 1 | Direct-transition enable |
| tmr_sel | input | 1 | Timer clock-select bit required for watch-based moves |
| settle_sel | input | 3 | Oscillator settling-time selector |
| dt_irq_en | input | 1 | Direct-transition interrupt enable |
| gmask | input | 1 | Global interrupt mask |
| wake_irq | input | 1 | Wake interrupt for plain sleep or watch |
| mode | output | 3 | Current mode code |
| clk_sel | output | 2 | Clock-speed select |
| cpu_halt | output | 1 | CPU halt request |
| dt_irq | output | 1 | Direct-transition interrupt request pulse |

## Verification
The bench pushes the subactive-to-high move through the shortest, a middle and the longest settling wait. A counter that is off by one or misreads the field lands one cycle early or late, or at the wrong length. It fires sleep and wake inputs during a direct pass-through and in running modes. A controller that does not ignore them would abort the move or fall asleep again. It covers the masked direct attempt, where a weak design would let a wake escape. It also covers the disabled-interrupt case, where a faulty design would carry on to the target or raise the request. Control patterns that match no path check that only the listed combinations move the part, and the clock select is watched on every cycle of every pass-through.

// File: rtl/pmc_pkg.sv
// Package pmc_pkg: shared mode codes, control bundle and clock-select
// encoding for the power-mode controller. Assumes 3-bit mode output.
package pmc_pkg;

    typedef enum logic [2:0] {
        PM_HIGH  = 3'd0,
        PM_MED   = 3'd1,
        PM_SUB   = 3'd2,
        PM_SLEEP = 3'd3,
        PM_WATCH = 3'd4
    } pm_mode_e;

    typedef struct packed {
        logic sby;   // standby select
        logic lspd;  // low-speed on
        logic mspd;  // medium-speed on
        logic dten;  // direct-transition enable
        logic tsel;  // timer clock select
    } pm_ctrl_t;

    localparam logic [1:0] CLK_HIGH = 2'b00;
    localparam logic [1:0] CLK_MED  = 2'b01;
    localparam logic [1:0] CLK_SUB  = 2'b10;

    // True for the three running modes.
    function automatic logic is_run(input pm_mode_e m);
        return (m == PM_HIGH) || (m == PM_MED) || (m == PM_SUB);
    endfunction

endpackage

// File: rtl/pmc_path_sel.sv
// Module pmc_path_sel: combinational decoder that, for the current running
// mode and control bits, says whether a legal direct path exists, where it
// lands, whether it passes through watch, and whether it needs a settling
// wait. Assumes it is only consulted while in a running mode.
module pmc_path_sel
    import pmc_pkg::*;
(
    input  pm_mode_e from_mode,
    input  pm_ctrl_t ctrl,
    output logic     path_ok,
    output pm_mode_e dest,
    output logic     via_watch,
    output logic     need_settle
);

    logic to_sub_ok;
    logic sleep_hop_ok;

    // Shared conditions: watch-based move to subactive, sleep-based speed swap.
    always_comb begin
        to_sub_ok    = ctrl.sby && ctrl.lspd && ctrl.tsel;
        sleep_hop_ok = !ctrl.sby && !ctrl.lspd;
    end

    // Per-mode path table.
    always_comb begin
        path_ok     = 1'b0;
        dest        = from_mode;
        via_watch   = ctrl.sby;
        need_settle = 1'b0;
        unique case (from_mode)
            PM_HIGH: begin
                if (to_sub_ok) begin
                    path_ok = 1'b1;
                    dest    = PM_SUB;
                end else if (sleep_hop_ok && ctrl.mspd) begin
                    path_ok = 1'b1;
                    dest    = PM_MED;
                end
            end
            PM_MED: begin
                if (to_sub_ok) begin
                    path_ok = 1'b1;
                    dest    = PM_SUB;
                end else if (sleep_hop_ok && !ctrl.mspd) begin
                    path_ok = 1'b1;
                    dest    = PM_HIGH;
                end
            end
            PM_SUB: begin
                if (ctrl.sby && !ctrl.lspd && !ctrl.mspd && ctrl.tsel) begin
                    path_ok     = 1'b1;
                    dest        = PM_HIGH;
                    need_settle = 1'b1;
                end
            end
            default: begin
                path_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pmc_settle_timer.sv
// Module pmc_settle_timer: down-counter that times a direct pass-through.
// On load it holds 2^(field+BASE_LOG2)-1 when a settling wait is wanted,
// else 0; done is high when the count has reached zero. Assumes tick is
// only raised while a direct pass-through is in progress.
module pmc_settle_timer #(
    parameter int FIELD_W   = 3,
    parameter int BASE_LOG2 = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               use_field,
    input  logic [FIELD_W-1:0] field,
    input  logic               tick,
    output logic               done
);

    localparam int CNT_W = BASE_LOG2 + (1 << FIELD_W) - 1;

    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] cnt_q;

    // Wait length selected by the field, one bit wider to hold the top value.
    always_comb begin
        span = (CNT_W+1)'(1) << (int'(field) + BASE_LOG2);
    end

    // Load on entry, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= use_field ? CNT_W'(span - 1'b1) : '0;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry flag.
    always_comb begin
        done = (cnt_q == '0);
    end

endmodule

// File: rtl/pmc_clk_map.sv
// Module pmc_clk_map: maps the latest running mode to the clock-speed
// select code. Assumes run_mode only ever holds a running mode.
module pmc_clk_map
    import pmc_pkg::*;
(
    input  pm_mode_e    run_mode,
    output logic [1:0]  clk_sel
);

    // Encoding lookup.
    always_comb begin
        unique case (run_mode)
            PM_MED:  clk_sel = CLK_MED;
            PM_SUB:  clk_sel = CLK_SUB;
            default: clk_sel = CLK_HIGH;
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module pwr_mode_ctrl: top-level mode state machine. It accepts sleep
// requests in running modes, steers them into plain sleep/watch or a direct
// transition, times the pass-through and lands in the target mode with a
// one-cycle interrupt pulse. Assumes sleep_req is a single-cycle pulse and
// all controls are synchronous to clk.
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int FIELD_W   = 3,
    parameter int BASE_LOG2 = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               sby_sel,
    input  logic               lspd_on,
    input  logic               mspd_on,
    input  logic               dt_en,
    input  logic               tmr_sel,
    input  logic [FIELD_W-1:0] settle_sel,
    input  logic               dt_irq_en,
    input  logic               gmask,
    input  logic               wake_irq,
    output logic [2:0]         mode,
    output logic [1:0]         clk_sel,
    output logic               cpu_halt,
    output logic               dt_irq
);

    pm_mode_e mode_q;
    pm_mode_e run_q;
    pm_mode_e dest_q;
    logic     direct_q;
    logic     locked_q;
    logic     irq_q;

    pm_ctrl_t ctrl;
    logic     path_ok;
    pm_mode_e path_dest;
    logic     via_watch;
    logic     need_settle;
    logic     in_run;
    logic     accept;
    logic     attempt;
    logic     go_direct;
    logic     timer_done;
    logic     wake_ok;

    // Bundle the control bits.
    always_comb begin
        ctrl.sby  = sby_sel;
        ctrl.lspd = lspd_on;
        ctrl.mspd = mspd_on;
        ctrl.dten = dt_en;
        ctrl.tsel = tmr_sel;
    end

    pmc_path_sel u_path (
        .from_mode   (mode_q),
        .ctrl        (ctrl),
        .path_ok     (path_ok),
        .dest        (path_dest),
        .via_watch   (via_watch),
        .need_settle (need_settle)
    );

    // Request classification for this cycle.
    always_comb begin
        in_run    = is_run(mode_q);
        accept    = in_run && sleep_req;
        attempt   = accept && ctrl.dten && path_ok;
        go_direct = attempt && !gmask && dt_irq_en;
        wake_ok   = wake_irq && !locked_q && !gmask;
    end

    pmc_settle_timer #(
        .FIELD_W   (FIELD_W),
        .BASE_LOG2 (BASE_LOG2)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .use_field (go_direct && need_settle),
        .field     (settle_sel),
        .tick      (direct_q && !in_run),
        .done      (timer_done)
    );

    // Mode sequencing: entry, pass-through, landing and wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= PM_HIGH;
            run_q    <= PM_HIGH;
            dest_q   <= PM_HIGH;
            direct_q <= 1'b0;
            locked_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (in_run) begin
                if (accept) begin
                    mode_q   <= (path_ok ? via_watch : ctrl.sby) ? PM_WATCH : PM_SLEEP;
                    direct_q <= go_direct;
                    locked_q <= attempt && gmask;
                    dest_q   <= path_dest;
                end
            end else if (direct_q) begin
                if (timer_done) begin
                    mode_q   <= dest_q;
                    run_q    <= dest_q;
                    direct_q <= 1'b0;
                    irq_q    <= 1'b1;
                end
            end else if (wake_ok) begin
                mode_q <= run_q;
            end
        end
    end

    pmc_clk_map u_clk (
        .run_mode (run_q),
        .clk_sel  (clk_sel)
    );

    // Output drive.
    always_comb begin
        mode     = mode_q;
        cpu_halt = !in_run;
        dt_irq   = irq_q;
    end

endmodule

// File: rtl/pmc_checker.sv
// Module pmc_checker: temporal properties on the controller's ports,
// attached to every pwr_mode_ctrl instance by bind.
module pmc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_req,
    input logic [2:0] mode,
    input logic [1:0] clk_sel,
    input logic       cpu_halt,
    input logic       dt_irq
);

    // Interrupt request never lasts two cycles.
    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dt_irq |=> !dt_irq);

    // Interrupt only when landing in a running mode from a halted state.
    assert_irq_landing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dt_irq |-> (!cpu_halt && $past(cpu_halt)));

    // Clock select never uses the spare code.
    assert_clk_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel != 2'b11);

    // Clock select changes only when leaving a halted state.
    assert_clk_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_sel) |-> (!cpu_halt && $past(cpu_halt)));

    // A sleep request in a running mode always halts next cycle.
    assert_enter_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !cpu_halt) |=> cpu_halt);

    // Mode code stays in the defined range.
    assert_mode_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mode <= 3'd4);

endmodule

bind pwr_mode_ctrl pmc_checker u_pmc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .mode      (mode),
    .clk_sel   (clk_sel),
    .cpu_halt  (cpu_halt),
    .dt_irq    (dt_irq)
);

// File: tb/pwr_mode_ctrl_bench.sv
// Bench: behavioural per-cycle reference model compared with the design on
// every falling edge; stimulus is driven on falling edges.
module pwr_mode_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       sby_sel = 1'b0;
    logic       lspd_on = 1'b0;
    logic       mspd_on = 1'b0;
    logic       dt_en = 1'b0;
    logic       tmr_sel = 1'b0;
    logic [2:0] settle_sel = 3'd0;
    logic       dt_irq_en = 1'b1;
    logic       gmask = 1'b0;
    logic       wake_irq = 1'b0;
    logic [2:0] mode;
    logic [1:0] clk_sel;
    logic       cpu_halt;
    logic       dt_irq;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    started = 0;
    bit    done = 0;

    // Reference model state.
    int m_mode = 0, m_run = 0, m_dest = 0, m_rem = 0;
    bit m_direct = 0, m_lock = 0, m_irq = 0;

    always #2 clk = ~clk;

    pwr_mode_ctrl u_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sby_sel(sby_sel),
        .lspd_on(lspd_on), .mspd_on(mspd_on), .dt_en(dt_en), .tmr_sel(tmr_sel),
        .settle_sel(settle_sel), .dt_irq_en(dt_irq_en), .gmask(gmask),
        .wake_irq(wake_irq), .mode(mode), .clk_sel(clk_sel),
        .cpu_halt(cpu_halt), .dt_irq(dt_irq)
    );

    // Target of a legal direct move from a running mode, or -1.
    function automatic int ref_target(int from);
        if (from == 2)
            return (sby_sel && !lspd_on && !mspd_on && tmr_sel) ? 0 : -1;
        if (sby_sel && lspd_on && tmr_sel) return 2;
        if (!sby_sel && !lspd_on) begin
            if (from == 0 && mspd_on) return 1;
            if (from == 1 && !mspd_on) return 0;
        end
        return -1;
    endfunction

    // Model update on each rising edge.
    always @(posedge clk) begin
        int d;
        started = 1;
        if (!rst_n) begin
            m_mode = 0; m_run = 0; m_dest = 0; m_rem = 0;
            m_direct = 0; m_lock = 0; m_irq = 0;
        end else begin
            m_irq = 0;
            if (m_mode <= 2) begin
                if (sleep_req) begin
                    d = ref_target(m_mode);
                    m_direct = 0;
                    m_lock = 0;
                    if (dt_en && d >= 0) begin
                        if (gmask) m_lock = 1;
                        else if (dt_irq_en) begin
                            m_direct = 1;
                            m_dest = d;
                            m_rem = (m_mode == 2) ? (1 << (settle_sel + 6)) : 1;
                        end
                    end
                    m_mode = sby_sel ? 4 : 3;
                end
            end else if (m_direct) begin
                m_rem = m_rem - 1;
                if (m_rem == 0) begin
                    m_mode = m_dest; m_run = m_dest; m_direct = 0; m_irq = 1;
                end
            end else if (wake_irq && !m_lock && !gmask) begin
                m_mode = m_run;
            end
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        int exp_clk;
        if (started && !done) begin
            exp_clk = (m_run == 0) ? 0 : (m_run == 1) ? 1 : 2;
            checks++;
            if (mode !== 3'(m_mode) || clk_sel !== 2'(exp_clk) ||
                cpu_halt !== (m_mode >= 3) || dt_irq !== m_irq) begin
                errors++;
                $display("FAIL %s t=%0t mode=%0d/%0d clk=%0d/%0d halt=%0b/%0b irq=%0b/%0b (actual/expected)",
                    tag, $time, mode, m_mode, clk_sel, exp_clk, cpu_halt, m_mode >= 3, dt_irq, m_irq);
            end
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_ctrl(bit sb, bit ls, bit ms, bit dt, bit ts);
        sby_sel = sb; lspd_on = ls; mspd_on = ms; dt_en = dt; tmr_sel = ts;
    endtask

    task automatic req();
        sleep_req = 1; @(negedge clk); sleep_req = 0;
    endtask

    task automatic wake();
        wake_irq = 1; @(negedge clk); wake_irq = 0;
    endtask

    // Directed port check beside the model comparison.
    task automatic expect_mode(string t, int m);
        checks++;
        if (mode !== 3'(m)) begin
            errors++;
            $display("FAIL %s mode actual=%0d expected=%0d", t, mode, m);
        end
    endtask

    // Watchdog.
    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        tag = "R1"; rst_n = 1; idle(2); expect_mode("R1", 0);
        // R2: high to medium
        tag = "R2"; set_ctrl(0, 0, 1, 1, 0); req(); expect_mode("R2", 3); idle(3); expect_mode("R2", 1);
        // R3: medium to high
        tag = "R3"; set_ctrl(0, 0, 0, 1, 0); req(); idle(3); expect_mode("R3", 0);
        // R4: high to sub
        tag = "R4"; set_ctrl(1, 1, 0, 1, 1); req(); expect_mode("R4", 4); idle(3); expect_mode("R4", 2);
        // R5 + R11: sub to high, shortest wait, with stray requests mid-wait
        tag = "R5"; settle_sel = 3'd0; set_ctrl(1, 0, 0, 1, 1); req();
        idle(20); tag = "R11"; req(); wake(); tag = "R5"; idle(60); expect_mode("R5", 0);
        // R4: medium to sub
        tag = "R4"; set_ctrl(0, 0, 1, 1, 0); req(); idle(3);
        set_ctrl(1, 1, 1, 1, 1); req(); idle(3); expect_mode("R4", 2);
        // R5: field 1 (128 cycles)
        tag = "R5"; settle_sel = 3'd1; set_ctrl(1, 0, 0, 1, 1); req(); idle(140); expect_mode("R5", 0);
        // R7: interrupt disabled, rests in sleep; wake returns
        tag = "R7"; dt_irq_en = 0; set_ctrl(0, 0, 1, 1, 0); req(); idle(6); expect_mode("R7", 3);
        wake(); idle(2); expect_mode("R7", 0); dt_irq_en = 1;
        // R9: plain watch, masked wake ignored, unmasked wake returns
        tag = "R9"; set_ctrl(1, 0, 0, 0, 0); req(); idle(3);
        gmask = 1; wake(); idle(2); expect_mode("R9", 4);
        gmask = 0; wake(); idle(2); expect_mode("R9", 0);
        // R11: wake in a running mode; non-matching direct pattern sleeps
        tag = "R11"; wake(); idle(2); expect_mode("R11", 0);
        set_ctrl(0, 0, 0, 1, 0); req(); idle(2); expect_mode("R11", 3); wake(); idle(2);
        // R10 + R5: longest wait, clock stays sub throughout
        tag = "R10"; set_ctrl(1, 1, 0, 1, 1); req(); idle(3);
        settle_sel = 3'd7; set_ctrl(1, 0, 0, 1, 1); req(); idle(8200); expect_mode("R5", 0);
        // R12 / R6 covered by every comparison; R8: masked direct attempt is locked
        tag = "R8"; gmask = 1; set_ctrl(0, 0, 1, 1, 0); req(); idle(3);
        gmask = 0; wake(); idle(3); expect_mode("R8", 3); wake(); idle(3); expect_mode("R8", 3);
        tag = "R6"; idle(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule